// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a word-addressed register mailbox placed between a host register bus and a secure coprocessor. The host fills sixteen argument registers and then writes a command word. That write takes a snapshot of the command together with all sixteen arguments and pushes it into a first-in, first-out queue of `DEPTH` entries. The coprocessor pulls entries through a valid/ready pop port.

When the coprocessor finishes a command, it pulses a done strobe carrying a return code and sixteen status words. The block latches these so the host can read them. Three events are recorded as interrupt causes: completion, a queue that has just become full, and a command write that was dropped because the queue was full. Each cause can be masked. A single level-sensitive interrupt line reports any cause that is not masked. Causes are cleared by writing ones to them.

The bus address `busAddr` is a word index, that is, the byte offset divided by four. Reads are combinational from the registers.

Top module: `cmd_mailbox`

## Requirements
- R1: Word indices 0..15 (byte offsets 0x00..0x3C) are sixteen read/write argument registers, reset to zero.
- R2: A write to word index 0x10 (byte 0x40) enqueues the written command word together with the argument registers as they stand in that cycle. Later argument writes do not alter an entry already queued.
- R3: The queue is first in, first out. `cmdValid` is high while the pending count is nonzero. An entry leaves the queue on a cycle where `cmdValid` and `cmdReady` are both high, and `cmdWord`/`cmdArgs` show the oldest entry, with argument i at bits [32*i+31:32*i].
- R4: Word index 0x31 (byte 0xC4) reads bit 8 = `coprocReady` and bits 2:0 = the pending count, which is at most `DEPTH` (4). All other bits read 0.
- R5: A command write while the count equals `DEPTH` is discarded, even if a pop happens in the same cycle, and it sets cause bit 17.
- R6: Cause bit 18 is set on the cycle the pending count becomes `DEPTH`.
- R7: A `doneStrobe` pulse latches `doneCode` into word index 0x20 (byte 0x80) and status word i into word index 0x21+i (bytes 0x84..0xC0), and it sets cause bit 0.
- R8: The cause register at word index 0x32 (byte 0xC8) reads the pending causes. A write clears every cause bit that is 1 in the written word, and a cause that is set in the same cycle stays set.
- R9: The mask register at word index 0x33 (byte 0xCC) is read/write and resets to all ones. `irq` is the OR over bits 0, 17 and 18 of cause AND NOT mask.
- R10: A push and a pop in the same cycle leave the pending count unchanged.
- R11: After reset the count is 0, `cmdValid` is 0, the cause register is 0 and `irq` is 0. Unmapped word indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Host write enable |
| busAddr | input | 6 | Host word index (byte offset / 4) |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Host read data (combinational) |
| coprocReady | input | 1 | Coprocessor ready level, shown in the queue status register |
| cmdValid | output | 1 | Queue holds at least one command |
| cmdReady | input | 1 | Coprocessor accepts the head entry |
| cmdWord | output | 32 | Command word of the head entry |
| cmdArgs | output | 512 | Sixteen argument words of the head entry |
| doneStrobe | input | 1 | One-cycle completion pulse |
| doneCode | input | 32 | Return code captured on completion |
| doneStatus | input | 512 | Sixteen status words captured on completion |
| irq | output | 1 | Level interrupt to the host |

## Verification
Two pairs of events can land in the same cycle. The first pair is a host command push and a coprocessor pop. The bench provokes this by raising `cmdReady` in the same cycle as the command write. It then judges the result through the pending count read back from the status register, and through a scoreboard that must see the pushed entry come out later in order. The second pair is a completion pulse and a host write that clears the completion cause. The bench drives both at once and expects bit 0 to read back as still set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_ARGS  = 16;
  localparam int ADDR_W    = 6;
  localparam int ARG_IDX_W = $clog2(NUM_ARGS);

  // Word indices of the register map
  localparam int WI_CMD    = 16;
  localparam int WI_RET    = 32;
  localparam int WI_RES    = 33;
  localparam int WI_QSTAT  = 49;
  localparam int WI_CAUSE  = 50;
  localparam int WI_MASK   = 51;

  // Cause bit positions
  localparam int CB_DONE = 0;
  localparam int CB_OVF  = 17;
  localparam int CB_FULL = 18;
  localparam int QSTAT_RDY_BIT = 8;

  localparam logic [DATA_W-1:0] CAUSE_ALL =
    (DATA_W'(1) << CB_DONE) | (DATA_W'(1) << CB_OVF) | (DATA_W'(1) << CB_FULL);

  typedef struct packed {
    logic argWr;
    logic push;
    logic pop;
    logic done;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              cmdReady,
  input  logic              doneStrobe,
  output mbxStrobes_t       strobes,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] cause,
  output logic [DATA_W-1:0] mask,
  output logic              cmdValid,
  output logic              irq
);
  logic cmdWr, causeWr, maskWr, isFull;
  logic [CNT_W-1:0]  countNext;
  logic [DATA_W-1:0] causeSet, causeClr;

  assign cmdWr   = busWe && (int'(busAddr) == WI_CMD);
  assign causeWr = busWe && (int'(busAddr) == WI_CAUSE);
  assign maskWr  = busWe && (int'(busAddr) == WI_MASK);
  assign isFull  = (int'(count) == DEPTH);
  assign cmdValid = (count != '0);

  always_comb begin
    strobes       = '0;
    strobes.argWr = busWe && (int'(busAddr) < NUM_ARGS);
    strobes.push  = cmdWr && !isFull;
    strobes.pop   = cmdValid && cmdReady;
    strobes.done  = doneStrobe;
  end

  assign countNext = count + CNT_W'(strobes.push) - CNT_W'(strobes.pop);

  always_comb begin
    causeSet = '0;
    causeSet[CB_DONE] = doneStrobe;
    causeSet[CB_OVF]  = cmdWr && isFull;
    causeSet[CB_FULL] = (int'(countNext) == DEPTH) && !isFull;
    causeClr = causeWr ? busWdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      cause <= '0;
      mask  <= '1;
    end else begin
      count <= countNext;
      cause <= ((cause & ~causeClr) | causeSet) & CAUSE_ALL;
      if (maskWr) mask <= busWdata;
    end
  end

  assign irq = |(cause & ~mask & CAUSE_ALL);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && isFull) |=> cause[CB_OVF]); // R5
  AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(int'(count) == DEPTH) |-> cause[CB_FULL]); // R6
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> cause[CB_DONE]); // R7
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (causeWr && busWdata[CB_DONE] && !doneStrobe) |=> !cause[CB_DONE]); // R8
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !isFull && cmdValid && cmdReady) |=> $stable(count)); // R10
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ARGS_W = NUM_ARGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobes_t       strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] cause,
  input  logic [DATA_W-1:0] mask,
  input  logic              coprocReady,
  input  logic [DATA_W-1:0] doneCode,
  input  logic [ARGS_W-1:0] doneStatus,
  output logic [DATA_W-1:0] cmdWord,
  output logic [ARGS_W-1:0] cmdArgs,
  output logic [DATA_W-1:0] busRdata
);
  logic [DATA_W-1:0] argRegs [NUM_ARGS];
  logic [DATA_W-1:0] resWords[NUM_ARGS];
  logic [DATA_W-1:0] retCode;
  logic [ARGS_W-1:0] argFlat;
  logic [DATA_W-1:0] qCmd [DEPTH];
  logic [ARGS_W-1:0] qArgs[DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  for (genvar i = 0; i < NUM_ARGS; i++) begin : g_args
    assign argFlat[i*DATA_W +: DATA_W] = argRegs[i];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        argRegs[i]  <= '0;
        resWords[i] <= '0;
      end else begin
        if (strobes.argWr && (int'(busAddr[ARG_IDX_W-1:0]) == i))
          argRegs[i] <= busWdata;
        if (strobes.done)
          resWords[i] <= doneStatus[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retCode <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
    end else begin
      if (strobes.done) retCode <= doneCode;
      if (strobes.push) begin
        qCmd[wrPtr]  <= busWdata;
        qArgs[wrPtr] <= argFlat;
        wrPtr <= (int'(wrPtr) == DEPTH - 1) ? '0 : wrPtr + 1'b1;
      end
      if (strobes.pop)
        rdPtr <= (int'(rdPtr) == DEPTH - 1) ? '0 : rdPtr + 1'b1;
    end
  end

  assign cmdWord = qCmd[rdPtr];
  assign cmdArgs = qArgs[rdPtr];

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NUM_ARGS; i++) begin
      if (int'(busAddr) == i)          busRdata = argRegs[i];
      if (int'(busAddr) == WI_RES + i) busRdata = resWords[i];
    end
    case (int'(busAddr))
      WI_RET:   busRdata = retCode;
      WI_QSTAT: begin
        busRdata[CNT_W-1:0]     = count;
        busRdata[QSTAT_RDY_BIT] = coprocReady;
      end
      WI_CAUSE: busRdata = cause;
      WI_MASK:  busRdata = mask;
      default: ;
    endcase
  end

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (int'(count) % DEPTH) == ((int'(wrPtr) - int'(rdPtr) + DEPTH) % DEPTH)); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (count != '0)); // R3
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWe,
  input  logic [5:0]                  busAddr,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic                        coprocReady,
  output logic                        cmdValid,
  input  logic                        cmdReady,
  output logic [31:0]                 cmdWord,
  output logic [511:0]                cmdArgs,
  input  logic                        doneStrobe,
  input  logic [31:0]                 doneCode,
  input  logic [511:0]                doneStatus,
  output logic                        irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  mbxStrobes_t       strobes;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] cause, mask;

  mbx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .cmdReady(cmdReady), .doneStrobe(doneStrobe),
    .strobes(strobes), .count(count), .cause(cause), .mask(mask),
    .cmdValid(cmdValid), .irq(irq)
  );

  mbx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .count(count), .cause(cause), .mask(mask),
    .coprocReady(coprocReady), .doneCode(doneCode), .doneStatus(doneStatus),
    .cmdWord(cmdWord), .cmdArgs(cmdArgs), .busRdata(busRdata)
  );

  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (mask[CB_DONE] && mask[CB_OVF] && mask[CB_FULL]) |-> !irq); // R9
  AST_IRQ_DONE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (cause[CB_DONE] && !mask[CB_DONE]) |-> irq); // R9
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_CMD = 6'h10, A_RET = 6'h20, A_RES0 = 6'h21,
                         A_RES15 = 6'h30, A_QST = 6'h31, A_CAUSE = 6'h32,
                         A_MASK = 6'h33;

  logic clk = 0, rstN = 0, busWe = 0, coprocReady = 0, cmdReady = 0, doneStrobe = 0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, doneCode = '0, busRdata, cmdWord;
  logic [511:0] doneStatus = '0, cmdArgs;
  logic cmdValid, irq;

  int checks = 0, errors = 0;
  logic [543:0] sbQueue[$];
  logic [31:0] argModel[16];
  logic [31:0] rd;

  cmd_mailbox u_cmd_mailbox (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .coprocReady(coprocReady), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdWord(cmdWord), .cmdArgs(cmdArgs),
    .doneStrobe(doneStrobe), .doneCode(doneCode), .doneStatus(doneStatus), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [543:0] snap(input logic [31:0] c);
    logic [511:0] a;
    for (int i = 0; i < 16; i++) a[i*32 +: 32] = argModel[i];
    return {c, a};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWe = 1; busAddr = a; busWdata = d;
    if (a < 6'h10) argModel[a[3:0]] = d;
    @(posedge clk); #1;
    busWe = 0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic sendCmd(input logic [31:0] c, input bit accept);
    if (accept) sbQueue.push_back(snap(c));
    doWrite(A_CMD, c);
  endtask

  task automatic popCycles(input int n);
    @(posedge clk); #1;
    cmdReady = 1;
    repeat (n) @(posedge clk);
    #1 cmdReady = 0;
  endtask

  // Monitor: compare each popped head entry against the scoreboard (R3, R2)
  always @(negedge clk) begin
    if (rstN && cmdValid && cmdReady) begin
      checks++;
      if (sbQueue.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected pop actual=%h expected=none", cmdWord);
      end else begin
        logic [543:0] e;
        e = sbQueue.pop_front();
        if ({cmdWord, cmdArgs} !== e) begin
          errors++;
          $display("FAIL R3/R2 pop entry actual=%h expected=%h", {cmdWord, cmdArgs}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) argModel[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R11 reset state
    @(negedge clk);
    check("R11 cmdValid", {31'b0, cmdValid}, 0);
    check("R11 irq", {31'b0, irq}, 0);
    doRead(A_QST, rd);  check("R11 count", rd, 0);
    doRead(A_CAUSE, rd); check("R11 cause", rd, 0);
    doRead(6'h3F, rd);  check("R11 unmapped", rd, 0);
    doRead(A_MASK, rd); check("R9 mask reset", rd, 32'hFFFF_FFFF);

    // R1 argument registers
    for (int i = 0; i < 16; i++) doWrite(6'(i), 32'hA000_0000 + i);
    doRead(6'h00, rd); check("R1 arg0", rd, 32'hA000_0000);
    doRead(6'h0F, rd); check("R1 arg15", rd, 32'hA000_000F);

    // R2/R4 push one command
    coprocReady = 1;
    sendCmd(32'h0000_00C1, 1);
    doRead(A_QST, rd); check("R4 status one pending", rd, 32'h0000_0101);
    coprocReady = 0;
    doRead(A_QST, rd); check("R4 status not ready", rd, 32'h0000_0001);
    check("R3 valid with pending", {31'b0, cmdValid}, 1);

    // R2 snapshot: change args between commands
    doWrite(6'h03, 32'hBBBB_0003);
    sendCmd(32'h0000_00C2, 1);
    doWrite(6'h07, 32'hCCCC_0007);
    sendCmd(32'h0000_00C3, 1);
    doRead(A_CAUSE, rd); check("R6 full not yet", rd, 32'h0);
    doWrite(6'h00, 32'hDDDD_0000);
    sendCmd(32'h0000_00C4, 1);
    doRead(A_QST, rd); check("R4 count full", rd, 32'h4);
    doRead(A_CAUSE, rd); check("R6 full cause", rd, 32'h0004_0000);

    // R5 overflow write discarded
    doWrite(6'h01, 32'hEEEE_0001);
    sendCmd(32'h0000_00C5, 0);
    doRead(A_QST, rd); check("R5 count stays full", rd, 32'h4);
    doRead(A_CAUSE, rd); check("R5 overflow cause", rd, 32'h0006_0000);

    // R9 mask and irq
    check("R9 irq masked", {31'b0, irq}, 0);
    doWrite(A_MASK, ~(32'h1 << 17));
    @(negedge clk); check("R9 irq overflow open", {31'b0, irq}, 1);
    doWrite(A_CAUSE, 32'h0006_0000);
    doRead(A_CAUSE, rd); check("R8 w1c clears", rd, 0);
    check("R9 irq cleared", {31'b0, irq}, 0);

    // R3 pop two
    popCycles(2);
    doRead(A_QST, rd); check("R3 count after two pops", rd, 32'h2);

    // R10 push and pop together
    @(posedge clk); #1;
    sbQueue.push_back(snap(32'h0000_00C6));
    busWe = 1; busAddr = A_CMD; busWdata = 32'h0000_00C6; cmdReady = 1;
    @(posedge clk); #1;
    busWe = 0; cmdReady = 0;
    doRead(A_QST, rd); check("R10 count unchanged", rd, 32'h2);

    // Drain
    popCycles(4);
    doRead(A_QST, rd); check("R3 drained", rd, 0);
    check("R3 valid low", {31'b0, cmdValid}, 0);
    check("R3 scoreboard empty", sbQueue.size(), 0);

    // R7 completion capture
    doWrite(A_MASK, 32'hFFFF_FFFE);
    @(posedge clk); #1;
    doneStrobe = 1; doneCode = 32'h0000_5A5A;
    for (int i = 0; i < 16; i++) doneStatus[i*32 +: 32] = 32'h5000_0000 + i * 3;
    @(posedge clk); #1;
    doneStrobe = 0; doneCode = '0; doneStatus = '0;
    doRead(A_RET, rd);   check("R7 return code", rd, 32'h0000_5A5A);
    doRead(A_RES0, rd);  check("R7 status0", rd, 32'h5000_0000);
    doRead(A_RES15, rd); check("R7 status15", rd, 32'h5000_002D);
    doRead(A_CAUSE, rd); check("R7 done cause", rd, 32'h1);
    check("R9 irq done", {31'b0, irq}, 1);

    // R8 set wins over clear in the same cycle
    @(posedge clk); #1;
    busWe = 1; busAddr = A_CAUSE; busWdata = 32'h1; doneStrobe = 1;
    @(posedge clk); #1;
    busWe = 0; doneStrobe = 0;
    doRead(A_CAUSE, rd); check("R8 set beats clear", rd, 32'h1);
    doWrite(A_CAUSE, 32'hFFFF_FFFF);
    doRead(A_CAUSE, rd); check("R8 final clear", rd, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule